// File: doc/BRIEF.md
# Planar Adaptive Route Computation Stage

This stage sits at the head of each input of a router in a three-dimensional mesh. When a head flit arrives, the stage reads three things from it: the coordinates of the current node, the coordinates of the destination node, and a one-bit plane tag. It returns the output port the packet takes next, the virtual-channel class for that hop, and the plane tag to write back into the head flit.

Routing moves through two planes in a fixed order. The first plane is X-Y and the second is Y-Z. Inside the active plane the packet may step in either dimension that still has distance to cover. When both can make progress, the stage compares the downstream credit counts of the two candidate ports and picks one. A packet leaves the X-Y plane only after its X offset is zero. After that it never routes in X again.

A route is registered one cycle after a head-flit valid pulse. Buffering, virtual-channel allocation, switch allocation and the crossbar are outside this stage.

Top module: `prc_route_unit`

## Requirements
- R1: `route_valid_o` is high in exactly the cycle after a cycle in which `hdr_valid_i` was sampled high, and is low otherwise. Without a header, `port_o`, `vc_o` and `plane_o` keep their last values.
- R2: While `rst_ni` is low and until the first header, `route_valid_o` is 0, `port_o` is 0 (local), `vc_o` is 0 and `plane_o` is 0.
- R3: The port codes are 0 local, 1 X plus, 2 X minus, 3 Y plus, 4 Y minus, 5 Z plus and 6 Z minus. A dimension's plus port is used when its destination coordinate is greater than its current coordinate, and its minus port when it is smaller.
- R4: With plane tag 0 and a nonzero X offset, the chosen port is an X or a Y port. The returned plane tag is 0 and the class is 0.
- R5: With plane tag 0 and nonzero X and Y offsets, the stage picks the productive Y port only if its credit count is strictly greater than that of the productive X port. Otherwise it picks X. The credit count of port k (k = 1..6) is the slice `credit_i[(k-1)*CRED_W +: CRED_W]`.
- R6: With plane tag 0 and a zero X offset, the packet leaves the X-Y plane. The returned plane tag is 1 and the route is computed in the Y-Z plane.
- R7: In the Y-Z plane with nonzero Y and Z offsets, the stage picks the productive Z port only if its credit count is strictly greater than that of the productive Y port. Otherwise it picks Y. With only one nonzero offset, that dimension is used.
- R8: With plane tag 1 the stage never selects an X port and ignores the X offset. The returned plane tag stays 1.
- R9: The class is 0 for X-Y plane hops and for local delivery, 1 for Y hops in the Y-Z plane, and 2 for Z hops.
- R10: When the Y and Z offsets are zero and either the X offset is zero or the tag is 1, the port is local (0), the class is 0 and the returned plane tag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hdr_valid_i | input | 1 | Head flit present this cycle |
| cur_x_i | input | COORD_W | Current node X |
| cur_y_i | input | COORD_W | Current node Y |
| cur_z_i | input | COORD_W | Current node Z |
| dst_x_i | input | COORD_W | Destination X |
| dst_y_i | input | COORD_W | Destination Y |
| dst_z_i | input | COORD_W | Destination Z |
| plane_i | input | 1 | Plane tag from the head flit: 0 X-Y, 1 Y-Z |
| credit_i | input | 6*CRED_W | Downstream credit count for each directional port |
| route_valid_o | output | 1 | Registered route is valid |
| port_o | output | 3 | Selected output port |
| vc_o | output | 2 | Virtual-channel class |
| plane_o | output | 1 | Updated plane tag |

## Verification
The hardest case to reach from the ports is a header that arrives in the Y-Z plane but still carries a nonzero X offset. A correct upstream never produces this header, yet the stage must still keep X out of the route. The bench sweeps every pair of current and destination coordinates on a small mesh under both plane tags, so this header and every tie between equal credit counts are reached. Credit patterns are drawn from a constant pattern, which forces ties, and from two patterns that shift with the coordinate index, so that each candidate port wins against the other somewhere in the sweep.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int NDIM   = 3;
  localparam int NDIR   = 2 * NDIM;
  localparam int PORT_W = 3;
  localparam int VC_W   = 2;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XN    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YN    = 3'd4,
    PORT_ZP    = 3'd5,
    PORT_ZN    = 3'd6
  } port_e;

  typedef struct packed {
    port_e            port;
    logic [VC_W-1:0]  vc;
    logic             plane;
  } route_t;
endpackage

// File: rtl/prc_dim_cmp.sv
module prc_dim_cmp #(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] cur_i,
  input  logic [COORD_W-1:0] dst_i,
  output logic               need_o,
  output logic               plus_o
);
  assign need_o = (cur_i != dst_i);
  assign plus_o = (dst_i > cur_i);
endmodule

// File: rtl/prc_pick.sv
// Adaptive choice between the two dimensions of a plane; ties go to the lower one.
module prc_pick #(
  parameter int CRED_W = 4
) (
  input  logic              lo_need_i,
  input  logic              hi_need_i,
  input  logic [CRED_W-1:0] lo_cred_i,
  input  logic [CRED_W-1:0] hi_cred_i,
  output logic              take_hi_o
);
  assign take_hi_o = hi_need_i & (~lo_need_i | (hi_cred_i > lo_cred_i));
endmodule

// File: rtl/prc_route_unit.sv
module prc_route_unit
  import prc_pkg::*;
#(
  parameter int COORD_W = 4,
  parameter int CRED_W  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hdr_valid_i,
  input  logic [COORD_W-1:0]     cur_x_i,
  input  logic [COORD_W-1:0]     cur_y_i,
  input  logic [COORD_W-1:0]     cur_z_i,
  input  logic [COORD_W-1:0]     dst_x_i,
  input  logic [COORD_W-1:0]     dst_y_i,
  input  logic [COORD_W-1:0]     dst_z_i,
  input  logic                   plane_i,
  input  logic [NDIR*CRED_W-1:0] credit_i,
  output logic                   route_valid_o,
  output logic [PORT_W-1:0]      port_o,
  output logic [VC_W-1:0]        vc_o,
  output logic                   plane_o
);
  localparam int DIM_X = 0;
  localparam int DIM_Y = 1;
  localparam int DIM_Z = 2;

  logic [COORD_W-1:0] cur [NDIM];
  logic [COORD_W-1:0] dst [NDIM];
  logic [NDIM-1:0]    need, plus;
  port_e              dim_port [NDIM];
  logic [CRED_W-1:0]  dim_cred [NDIM];

  assign cur[DIM_X] = cur_x_i;
  assign cur[DIM_Y] = cur_y_i;
  assign cur[DIM_Z] = cur_z_i;
  assign dst[DIM_X] = dst_x_i;
  assign dst[DIM_Y] = dst_y_i;
  assign dst[DIM_Z] = dst_z_i;

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    prc_dim_cmp #(.COORD_W(COORD_W)) u_cmp (
      .cur_i  (cur[d]),
      .dst_i  (dst[d]),
      .need_o (need[d]),
      .plus_o (plus[d])
    );
    assign dim_port[d] = plus[d] ? port_e'(PORT_W'(2*d+1)) : port_e'(PORT_W'(2*d+2));
    assign dim_cred[d] = plus[d] ? credit_i[(2*d)*CRED_W +: CRED_W]
                                 : credit_i[(2*d+1)*CRED_W +: CRED_W];
  end

  logic xy_take_y, yz_take_z;

  prc_pick #(.CRED_W(CRED_W)) u_pick_xy (
    .lo_need_i (need[DIM_X]),
    .hi_need_i (need[DIM_Y]),
    .lo_cred_i (dim_cred[DIM_X]),
    .hi_cred_i (dim_cred[DIM_Y]),
    .take_hi_o (xy_take_y)
  );

  prc_pick #(.CRED_W(CRED_W)) u_pick_yz (
    .lo_need_i (need[DIM_Y]),
    .hi_need_i (need[DIM_Z]),
    .lo_cred_i (dim_cred[DIM_Y]),
    .hi_cred_i (dim_cred[DIM_Z]),
    .take_hi_o (yz_take_z)
  );

  // X-Y plane is left for good once X is resolved or the tag says so
  logic   leave_xy;
  route_t nxt, cur_rt;

  assign leave_xy = plane_i | ~need[DIM_X];

  always_comb begin
    nxt = '{port: PORT_LOCAL, vc: '0, plane: 1'b1};
    if (!leave_xy) begin
      nxt.port  = xy_take_y ? dim_port[DIM_Y] : dim_port[DIM_X];
      nxt.vc    = '0;
      nxt.plane = 1'b0;
    end else if (need[DIM_Y] | need[DIM_Z]) begin
      nxt.port  = yz_take_z ? dim_port[DIM_Z] : dim_port[DIM_Y];
      nxt.vc    = yz_take_z ? VC_W'(2) : VC_W'(1);
      nxt.plane = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_valid_o <= 1'b0;
      cur_rt        <= '{port: PORT_LOCAL, vc: '0, plane: 1'b0};
    end else begin
      route_valid_o <= hdr_valid_i;
      if (hdr_valid_i) cur_rt <= nxt;
    end
  end

  assign port_o  = cur_rt.port;
  assign vc_o    = cur_rt.vc;
  assign plane_o = cur_rt.plane;

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> route_valid_o);
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_i |=> (!route_valid_o && $stable(port_o) && $stable(vc_o) && $stable(plane_o)));
  // R4
  xy_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && !plane_i && cur_x_i != dst_x_i) |=>
      (!plane_o && vc_o == '0 && port_o >= 3'd1 && port_o <= 3'd4));
  // R8
  yz_no_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && plane_i) |=> (plane_o && port_o != 3'd1 && port_o != 3'd2));
  // R9
  z_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_valid_o && (port_o == 3'd5 || port_o == 3'd6)) |-> vc_o == 2'd2);
  // R10
  local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && cur_y_i == dst_y_i && cur_z_i == dst_z_i && cur_x_i == dst_x_i) |=>
      (port_o == 3'd0 && vc_o == '0 && plane_o));
  // R3
  port_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_valid_o |-> port_o <= 3'd6);
endmodule

// File: tb/tb_prc_route_unit.sv
`timescale 1ns/1ps
module tb_prc_route_unit;
  localparam int CW  = 2;
  localparam int RW  = 2;
  localparam int NP  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv = 1'b0;
  logic [CW-1:0] cx = '0, cy = '0, cz = '0, dx = '0, dy = '0, dz = '0;
  logic pl = 1'b0;
  logic [NP*RW-1:0] cred = '0;
  logic rv;
  logic [2:0] port;
  logic [1:0] vc;
  logic plo;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prc_route_unit #(.COORD_W(CW), .CRED_W(RW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(hv),
    .cur_x_i(cx), .cur_y_i(cy), .cur_z_i(cz),
    .dst_x_i(dx), .dst_y_i(dy), .dst_z_i(dz),
    .plane_i(pl), .credit_i(cred),
    .route_valid_o(rv), .port_o(port), .vc_o(vc), .plane_o(plo)
  );

  function automatic int cr_of(input logic [NP*RW-1:0] c, input int k);
    return int'(c[(k-1)*RW +: RW]);
  endfunction

  function automatic int dport(input int d, input int c, input int t);
    return (t > c) ? 2*d+1 : 2*d+2;
  endfunction

  // Expected route computed from the requirements
  function automatic void model(input int p, input int c0, input int c1, input int c2,
                                input int t0, input int t1, input int t2,
                                input logic [NP*RW-1:0] c,
                                output int ep, output int ev, output int epl, output string tag);
    int px, py, pz;
    px = dport(0, c0, t0); py = dport(1, c1, t1); pz = dport(2, c2, t2);
    if (p == 0 && c0 != t0) begin
      epl = 0; ev = 0;
      if (c1 != t1) begin
        ep = (cr_of(c, py) > cr_of(c, px)) ? py : px; tag = "R5";
      end else begin
        ep = px; tag = "R4";
      end
    end else begin
      epl = 1;
      if (c1 != t1 && c2 != t2) begin
        ep = (cr_of(c, pz) > cr_of(c, py)) ? pz : py; tag = "R7";
      end else if (c1 != t1) begin
        ep = py; tag = (p == 1) ? "R8" : "R6";
      end else if (c2 != t2) begin
        ep = pz; tag = (p == 1) ? "R8" : "R6";
      end else begin
        ep = 0; tag = "R10";
      end
      ev = (ep == 5 || ep == 6) ? 2 : ((ep == 3 || ep == 4) ? 1 : 0);
    end
  endfunction

  task automatic check_rt(input string tag, input int ep, input int ev, input int epl);
    total++;
    if (int'(port) != ep || int'(vc) != ev || int'(plo) != epl) begin
      fails++;
      $display("FAIL %s: port/vc/plane actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, port, vc, plo, ep, ev, epl);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: route_valid actual %0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL R1: watchdog actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int ep, ev, epl;
    string tag;
    repeat (3) @(negedge clk);
    // R2 during reset
    check_bit("R2", rv, 1'b0);
    check_rt("R2", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R2", rv, 1'b0);
    check_rt("R2", 0, 0, 0);

    for (int p = 0; p < 2; p++) begin
      for (int idx = 0; idx < 4096; idx++) begin
        for (int pi = 0; pi < 3; pi++) begin
          pl = p[0];
          cx = CW'(idx); cy = CW'(idx >> 2); cz = CW'(idx >> 4);
          dx = CW'(idx >> 6); dy = CW'(idx >> 8); dz = CW'(idx >> 10);
          for (int k = 1; k <= NP; k++)
            cred[(k-1)*RW +: RW] = (pi == 0) ? RW'(2) : RW'(k*(pi+1) + idx);
          hv = 1'b1;
          model(p, int'(cx), int'(cy), int'(cz), int'(dx), int'(dy), int'(dz), cred,
                ep, ev, epl, tag);
          @(negedge clk);
          // R3 covered by every directional result; R9 by every class value
          check_bit("R1", rv, 1'b1);
          check_rt(tag, ep, ev, epl);
          if (idx % 512 == 0 && pi == 0) begin
            hv = 1'b0;
            pl = ~pl; cx = ~cx; dz = ~dz;
            @(negedge clk);
            check_bit("R1", rv, 1'b0);
            check_rt("R1", ep, ev, epl);
          end
        end
      end
    end
    hv = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule